// File: doc/BRIEF.md
# Programmable Integer Clock Divider with Deferred Update and Lock Handshake

This block divides an input clock by an integer ratio set through a control word. The word gives the length of the high phase and the low phase separately, in input clock cycles, so the ratio is their sum. For odd ratios a half-cycle select bit stretches the high phase by half an input cycle, which gives an even duty cycle. A bypass bit routes the input clock straight to the output.

Software writes the control word into a shadow register through a plain write strobe. A word with its no-update bit set is only stored. A word with that bit clear also requests an update. The requested setting is moved into the running divider only at the end of the current output period, so no short pulse is produced. The lock flag falls as soon as the update is requested. It rises again a fixed number of input cycles after the new setting has been loaded.

The sequencing is a three-state machine. `ST_LOCKED` is the idle state with the lock flag high. A triggering write takes it to `ST_WAIT_END` (transition "request"). `ST_WAIT_END` moves to `ST_SETTLE` on the edge that ends the output period; on that edge the shadow is applied (transition "apply"). `ST_SETTLE` goes back to `ST_LOCKED` after the settle count expires (transition "settled"). A triggering write in `ST_SETTLE` returns it to `ST_WAIT_END` (transition "restart"). A triggering write in `ST_WAIT_END` keeps it there and takes priority over an apply on the same edge.

Top module: `ckdv_top`

## Requirements
- R1: After reset the output follows the input clock (bypass), the lock flag is 1, and the control readback is 0x00002000.
- R2: Control word fields: low count [5:0], high count [11:6], half-cycle select bit 12, bypass bit 13, no-update bit 14. Bits [31:15] are ignored on write and read back as 0. With rd_sel=0 rd_data returns the shadow word; with rd_sel=1 it returns the lock flag in bit 0 and zeros above it.
- R3: With bit 12 = 0 and bypass clear, each output period is low+high input cycles. It starts with a high phase of `high` input cycles, followed by a low phase of `low` cycles.
- R4: With bit 12 = 1 the high phase lasts high+0.5 input cycles and the low phase lasts low−0.5. An odd ratio N coded as low = N/2+1, high = N/2 therefore gives equal phases.
- R5: With the bypass bit set, or with a low or high count of zero, the output equals the input clock.
- R6: A write with bit 14 = 1 only updates the shadow. The output waveform and the lock flag stay unchanged.
- R7: A write with bit 14 = 0 requests an update. The lock flag reads 0 from the cycle after the write edge.
- R8: The requested setting is loaded on the input edge that ends the current output period. When the divider is in bypass, that is the next edge. The old period completes in full, and the first new period begins with its high phase.
- R9: The lock flag returns to 1 sixteen (LOCK_CYCLES) input edges after the loading edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_sel | input | 1 | Readback select: 0 control word, 1 lock status |
| rd_data | output | 32 | Readback data |
| clk_out | output | 1 | Divided or bypassed output clock |
| locked | output | 1 | Lock flag: 1 when the divider runs with the requested setting |

## Verification
The lock flag drops in the cycle after the write edge, and the bench samples it 1 ns after that edge. A new setting loads on the edge that ends the output period in progress. The bench therefore times each triggering write one cycle after an output rising edge. It then expects one complete old period (two in bypass, since the bypass period is one cycle) before the new high phase. The lock flag returns 16 edges after the loading edge, so the expected count from the write edge is old ratio + 15, or 17 from bypass. Waveform shape is checked in half-cycle units, with clk_out sampled 1 ns after every input edge. The expected high and low run lengths are computed from the written fields.

// File: rtl/ckdv_pkg.sv
package ckdv_pkg;
    localparam int CNT_W   = 6;
    localparam int RATIO_W = CNT_W + 1;
    localparam int WORD_W  = 2 * CNT_W + 3;

    typedef struct packed {
        logic             noupd;
        logic             byp;
        logic             half_sel;
        logic [CNT_W-1:0] hi;
        logic [CNT_W-1:0] lo;
    } ckdv_word_t;

    typedef enum logic [1:0] {
        ST_LOCKED   = 2'd0,
        ST_WAIT_END = 2'd1,
        ST_SETTLE   = 2'd2
    } ckdv_state_t;
endpackage

// File: rtl/ckdv_ctrl.sv
module ckdv_ctrl
    import ckdv_pkg::*;
#(
    parameter int LOCK_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  ckdv_word_t wr_word,
    input  logic       period_end,
    output ckdv_word_t shadow,
    output logic       apply,
    output logic       locked
);
    localparam int SET_W = $clog2(LOCK_CYCLES + 1);
    localparam logic [SET_W-1:0] SET_LAST = SET_W'(LOCK_CYCLES - 1);

    ckdv_state_t      state, state_nxt;
    logic [SET_W-1:0] settle_cnt;
    logic             trigger;

    assign trigger = wr_en && !wr_word.noupd;

    // shadow copy of the control word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow     <= '0;
            shadow.byp <= 1'b1;
        end else if (wr_en) begin
            shadow <= wr_word;
        end
    end

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_LOCKED:   if (trigger) state_nxt = ST_WAIT_END;
            ST_WAIT_END: if (!trigger && period_end) state_nxt = ST_SETTLE;
            ST_SETTLE: begin
                if (trigger)                     state_nxt = ST_WAIT_END;
                else if (settle_cnt == SET_LAST) state_nxt = ST_LOCKED;
            end
            default:     state_nxt = ST_LOCKED;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_LOCKED;
        else        state <= state_nxt;
    end

    // settle window counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  settle_cnt <= '0;
        else if (state == ST_SETTLE) settle_cnt <= settle_cnt + 1'b1;
        else                         settle_cnt <= '0;
    end

    // outputs
    always_comb begin
        locked = (state == ST_LOCKED);
        apply  = (state == ST_WAIT_END) && period_end && !trigger;
    end

    a_r7_lock_drops: assert property (@(posedge clk) disable iff (!rst_n)
        trigger |=> !locked);
    a_r6_noupd_keeps_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_word.noupd && locked) |=> locked);
    a_r9_full_settle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(settle_cnt) == SET_LAST);
endmodule

// File: rtl/ckdv_gen.sv
module ckdv_gen
    import ckdv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       apply,
    input  ckdv_word_t new_word,
    output logic       period_end,
    output logic       clk_out
);
    logic [CNT_W-1:0]   act_lo, act_hi;
    logic               act_half, act_byp, new_byp;
    logic [RATIO_W-1:0] ratio, cnt, cnt_nxt;
    logic               div_q, div_n;

    always_comb begin
        ratio      = {1'b0, act_lo} + {1'b0, act_hi};
        period_end = act_byp || (cnt == ratio - 1'b1);
        cnt_nxt    = period_end ? '0 : cnt + 1'b1;
        new_byp    = new_word.byp || (new_word.lo == '0) || (new_word.hi == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_lo   <= '0;
            act_hi   <= '0;
            act_half <= 1'b0;
            act_byp  <= 1'b1;
            cnt      <= '0;
            div_q    <= 1'b0;
        end else if (apply) begin
            act_lo   <= new_word.lo;
            act_hi   <= new_word.hi;
            act_half <= new_word.half_sel;
            act_byp  <= new_byp;
            cnt      <= '0;
            div_q    <= !new_byp;
        end else if (act_byp) begin
            cnt   <= '0;
            div_q <= 1'b0;
        end else begin
            cnt   <= cnt_nxt;
            div_q <= (cnt_nxt < {1'b0, act_hi});
        end
    end

    // half-cycle delayed copy for odd ratios
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) div_n <= 1'b0;
        else        div_n <= div_q;
    end

    assign clk_out = act_byp ? clk : (act_half ? (div_q | div_n) : div_q);

    a_r8_apply_at_period_end: assert property (@(posedge clk) disable iff (!rst_n)
        apply |-> period_end);
    a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        !act_byp |-> cnt < ratio);
endmodule

// File: rtl/ckdv_top.sv
module ckdv_top
    import ckdv_pkg::*;
#(
    parameter int LOCK_CYCLES = 16
) (
    input  logic        clk_in,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        rd_sel,
    output logic [31:0] rd_data,
    output logic        clk_out,
    output logic        locked
);
    ckdv_word_t wr_word, shadow;
    logic       apply, period_end;

    assign wr_word = ckdv_word_t'(wr_data[WORD_W-1:0]);

    ckdv_ctrl #(.LOCK_CYCLES(LOCK_CYCLES)) u_ctrl (
        .clk        (clk_in),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_word    (wr_word),
        .period_end (period_end),
        .shadow     (shadow),
        .apply      (apply),
        .locked     (locked)
    );

    ckdv_gen u_gen (
        .clk        (clk_in),
        .rst_n      (rst_n),
        .apply      (apply),
        .new_word   (shadow),
        .period_end (period_end),
        .clk_out    (clk_out)
    );

    assign rd_data = rd_sel ? {31'b0, locked} : {{(32-WORD_W){1'b0}}, shadow};
endmodule

// File: tb/sim_ckdv_top.sv
module sim_ckdv_top;
    localparam int LOCK = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic        clk_out, locked;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    logic        smp;
    logic        lk_done;
    logic [31:0] old_w;
    bit          finished = 0;

    ckdv_top #(.LOCK_CYCLES(LOCK)) u0 (
        .clk_in(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .clk_out(clk_out), .locked(locked)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(int n);
        int lo = (n % 2 == 0) ? n / 2 : n / 2 + 1;
        return ((n % 2) << 12) | ((n / 2) << 6) | lo;
    endfunction

    function automatic bit eff_byp(logic [31:0] w);
        return w[13] || (w[5:0] == 0) || (w[11:6] == 0);
    endfunction
    function automatic int exp_h(logic [31:0] w);
        return eff_byp(w) ? 1 : 2 * int'(w[11:6]) + int'(w[12]);
    endfunction
    function automatic int exp_l(logic [31:0] w);
        return eff_byp(w) ? 1 : 2 * int'(w[5:0]) - int'(w[12]);
    endfunction
    function automatic string tag_of(logic [31:0] w);
        if (eff_byp(w)) return "R5 bypass wave";
        if (w[12])      return "R4 half-cycle wave";
        return "R3 divide wave";
    endfunction

    // sample clk_out 1 ns after every input edge
    task automatic hc();
        @(clk);
        #1 smp = clk_out;
    endtask

    // returns at the sample just after a rising output edge aligned to clk posedge
    task automatic wait_rise();
        logic prev;
        hc();
        for (int i = 0; i < 2000; i++) begin
            prev = smp;
            hc();
            if (clk && !prev && smp) break;
        end
    endtask

    // current sample is the first high half; measure high and low runs
    task automatic measure(output int h, output int l);
        h = 1; l = 0;
        for (int i = 0; i < 600; i++) begin hc(); if (!smp) break; h++; end
        l = 1;
        for (int i = 0; i < 600; i++) begin hc(); if (smp) break; l++; end
    endtask

    task automatic pulse_wr(logic [31:0] w);
        wr_data = w;
        wr_en   = 1'b1;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic watch_lock(int e);
        int n = 0;
        @(posedge clk);
        #1 chk("R7 lock falls after trigger", int'(locked), 0);
        while (!locked && n < 2000) begin
            @(posedge clk);
            #1 n++;
        end
        chk("R9 lock latency from write edge", n, e);
        lk_done = 1'b1;
    endtask

    task automatic prog_check(logic [31:0] w);
        int h, l, e;
        e = eff_byp(old_w) ? LOCK + 1 : int'(old_w[5:0]) + int'(old_w[11:6]) + LOCK - 1;
        wait_rise();
        lk_done = 1'b0;
        fork
            pulse_wr(w);
            watch_lock(e);
        join_none
        measure(h, l);
        chk("R8 old high completes", h, exp_h(old_w));
        chk("R8 old low completes", l, exp_l(old_w));
        if (eff_byp(old_w)) measure(h, l);
        measure(h, l);
        chk({tag_of(w), " first high (R8)"}, h, exp_h(w));
        chk({tag_of(w), " first low"}, l, exp_l(w));
        measure(h, l);
        chk({tag_of(w), " high"}, h, exp_h(w));
        chk({tag_of(w), " low"}, l, exp_l(w));
        wait (lk_done);
        rd_sel = 1'b0;
        #0 chk("R2 readback of written word", int'(rd_data), int'(w & 32'h7FFF));
        old_w = w & 32'h7FFF;
    endtask

    task automatic noupd_check(logic [31:0] w);
        int h, l;
        wait_rise();
        fork
            pulse_wr(w);
        join_none
        for (int k = 0; k < 3; k++) begin
            measure(h, l);
            chk("R6 stored word leaves high phase", h, exp_h(old_w));
            chk("R6 stored word leaves low phase", l, exp_l(old_w));
        end
        chk("R6 lock stays high", int'(locked), 1);
        rd_sel = 1'b1;
        #1 chk("R2 lock status readback", int'(rd_data), 1);
        rd_sel = 1'b0;
        #1 chk("R2 reserved bits read zero", int'(rd_data), int'(w & 32'h7FFF));
    endtask

    initial begin
        logic [31:0] w;
        void'($urandom(32'hC1D5));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk("R1 lock after reset", int'(locked), 1);
        chk("R1 control readback after reset", int'(rd_data), 32'h2000);
        @(posedge clk); #1 chk("R1 bypass high half", int'(clk_out), 1);
        @(negedge clk); #1 chk("R1 bypass low half", int'(clk_out), 0);
        old_w = 32'h2000;

        prog_check(enc(4));
        prog_check(enc(7));
        prog_check(enc(9));
        prog_check(32'h0000_2000);
        prog_check(enc(2));
        prog_check(32'h0000_0005);           // high count zero
        prog_check(enc(3));
        prog_check(32'h0000_1041);           // lo=1 hi=1 half-cycle
        noupd_check(32'hFFFF_8000 | 32'h4000 | enc(6));
        prog_check(enc(6));
        prog_check(32'h0000_0180);           // low count zero
        for (int i = 0; i < 12; i++) begin
            if ($urandom % 3 == 0)
                w = (($urandom % 2) << 12) | ((1 + $urandom % 20) << 6) | (1 + $urandom % 20);
            else
                w = enc(2 + $urandom % 30);
            if ($urandom % 4 == 0) noupd_check(w | 32'h4000);
            prog_check(w);
        end

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule